// File: doc/BRIEF.md
# Streaming Above-Threshold Waveform Chunker

This block watches one free-running digitized waveform channel. It forwards only short windows of samples that surround points where the signal rises above a programmable threshold. Nothing gates the input stream. Every accepted sample is examined, and all samples that are not part of a window are discarded.

Each window carries a few samples of context before its first over-threshold sample and after its last one. When neighbouring windows touch or overlap, they merge into one. A window that grows past a fixed maximum length is closed, and the next window continues from the following sample.

The block packs each window into a 32-bit output stream. A header word comes first and holds the channel number, the timestamp of the window's first sample and the window length. The header is followed by one word per sample. Words are buffered in an internal FIFO, and a window becomes visible on the output only once it is complete. If the FIFO lacks room for a full-size window at the moment a window would start, that window is dropped whole and a saturating overflow counter advances.

Top module: `wave_chunker`

## Requirements
- R1: After reset, outValid is 0 and overflowCount is 0.
- R2: With the default parameters (2 context samples before, 2 after), an isolated over-threshold sample at index h yields one window of the samples at indices h-2 through h+2, in stream order.
- R3: The header word holds the channel number in bits [31:27], the timestamp of the window's first sample in bits [26:7] and the sample count in bits [6:0]. The timestamp is the 20-bit index of that sample among all accepted samples since reset, counting from 0. Each sample word carries the sample in bits [9:0], with zeros above.
- R4: A sample counts as over threshold only when strictly greater than threshold. A sample equal to threshold, with no over-threshold sample near it, produces no output.
- R5: Two over-threshold samples whose indices differ by at most 5 (before + after + 1) share one window. A difference of 6 gives two separate windows.
- R6: A window that would exceed 64 samples is closed at 64. The next sample starts a new window with its own header and timestamp.
- R7: If fewer than 65 FIFO words are free when a window would start, the whole window is dropped and overflowCount increases by exactly 1. Later windows are accepted once room returns.
- R8: Words of a window reach the output only after the window has closed, with the header as the first word.
- R9: While outValid is 1 and outReady is 0, outValid stays 1 and outData does not change.
- R10: Cycles with sampleValid low are ignored: they advance neither timestamps nor windows, and they do not change overflowCount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | A new sample is present this cycle |
| sampleData | input | 10 | Sample value |
| threshold | input | 10 | Over-threshold comparison level |
| channelId | input | 5 | Channel number placed in headers |
| outReady | input | 1 | Downstream accepts a word |
| outValid | output | 1 | outData holds a word |
| outData | output | 32 | Header or sample word |
| overflowCount | output | 16 | Windows dropped for lack of space, saturating |

## Verification
The bench targets the boundaries of the window logic:
- A sample exactly at threshold must stay silent; a comparator using greater-or-equal would emit a spurious window.
- Hits five and six samples apart separate a correct merge from an off-by-one that fuses or splits windows.
- A 70-sample run checks the 64-sample split and the timestamp of the second header. A wrong cap either produces an oversize length field or loses a sample at the seam.
- Idle input cycles inside a window would shift timestamps or truncate context if they were counted.
- Filling the FIFO with output held off checks that exactly one window vanishes whole, rather than being partly written or corrupting earlier windows.
- Output stays hidden while a window is still open.

// File: rtl/chunk_pkg.sv
package chunk_pkg;
  localparam int SAMPLE_W = 10;
  localparam int CHAN_W   = 5;
  localparam int TS_W     = 20;
  localparam int LEN_W    = 7;
  localparam int WORD_W   = CHAN_W + TS_W + LEN_W;

  typedef struct packed {
    logic             startHead;
    logic             wrSample;
    logic             wrHeader;
    logic [LEN_W-1:0] hdrLen;
  } chunkStrobe_t;
endpackage

// File: rtl/chunk_ctrl.sv
module chunk_ctrl
  import chunk_pkg::*;
#(
  parameter int PRE    = 2,
  parameter int POST   = 2,
  parameter int MAXLEN = 64,
  parameter int OVF_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleValid,
  input  logic              over,
  input  logic              delayedValid,
  input  logic              spaceOk,
  output chunkStrobe_t      st,
  output logic [OVF_W-1:0]  overflowCount
);
  localparam int KEEP = PRE + POST + 1;
  localparam int KW   = $clog2(KEEP + 1);

  logic [KW-1:0]    keepCnt, keepEff;
  logic [LEN_W-1:0] lenCnt;
  logic             isOpen, isDrop, keep, capHit, startNew, stepIn;

  always_comb begin
    keepEff  = over ? KW'(KEEP) : keepCnt;
    stepIn   = sampleValid && delayedValid;
    keep     = stepIn && (keepEff != '0);
    capHit   = (lenCnt == LEN_W'(MAXLEN));
    startNew = keep && (!isOpen || capHit);
    st        = '0;
    st.hdrLen = lenCnt;
    if (keep) begin
      if (startNew) begin
        st.wrHeader  = isOpen && !isDrop;
        st.startHead = spaceOk;
        st.wrSample  = spaceOk;
      end else begin
        st.wrSample  = !isDrop;
      end
    end else if (stepIn && isOpen) begin
      st.wrHeader = !isDrop;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      keepCnt       <= '0;
      lenCnt        <= '0;
      isOpen        <= 1'b0;
      isDrop        <= 1'b0;
      overflowCount <= '0;
    end else if (sampleValid) begin
      keepCnt <= (keepEff != '0) ? keepEff - KW'(1) : '0;
      if (startNew) begin
        isOpen <= 1'b1;
        isDrop <= !spaceOk;
        lenCnt <= LEN_W'(1);
        if (!spaceOk && overflowCount != '1)
          overflowCount <= overflowCount + OVF_W'(1);
      end else if (keep) begin
        lenCnt <= lenCnt + LEN_W'(1);
      end else if (stepIn && isOpen) begin
        isOpen <= 1'b0;
        lenCnt <= '0;
      end
    end
  end
endmodule

// File: rtl/chunk_datapath.sv
module chunk_datapath
  import chunk_pkg::*;
#(
  parameter int PRE    = 2,
  parameter int DEPTH  = 256,
  parameter int MAXLEN = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic [CHAN_W-1:0]   channelId,
  input  chunkStrobe_t        st,
  output logic                over,
  output logic                delayedValid,
  output logic                spaceOk,
  input  logic                outReady,
  output logic                outValid,
  output logic [WORD_W-1:0]   outData
);
  localparam int AW = $clog2(DEPTH);
  localparam int SW = $clog2(PRE + 2);
  localparam logic [AW:0] NEED = (AW+1)'(MAXLEN + 1);

  logic [SAMPLE_W-1:0] delayedSample;
  logic [SW-1:0]       seenCnt;
  logic [TS_W-1:0]     tsCount, headTs;
  logic [AW:0]         fillPtr, commitPtr, rdPtr, headPtr, used, sampleAddr;
  logic [WORD_W-1:0]   mem [DEPTH];

  generate
    if (PRE > 0) begin : g_delay
      logic [SAMPLE_W-1:0] dly [PRE];
      always_ff @(posedge clk) begin
        if (sampleValid) begin
          dly[0] <= sampleData;
          for (int i = 1; i < PRE; i++) dly[i] <= dly[i-1];
        end
      end
      assign delayedSample = dly[PRE-1];
    end else begin : g_nodelay
      assign delayedSample = sampleData;
    end
  endgenerate

  assign over         = sampleData > threshold;
  assign delayedValid = (seenCnt == SW'(PRE));
  assign used         = fillPtr - rdPtr;
  assign spaceOk      = ((AW+1)'(DEPTH) - used) >= NEED;
  assign sampleAddr   = st.startHead ? fillPtr + (AW+1)'(1) : fillPtr;
  assign outValid     = (rdPtr != commitPtr);
  assign outData      = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (st.wrHeader)
      mem[headPtr[AW-1:0]] <= {channelId, headTs, st.hdrLen};
    if (st.wrSample)
      mem[sampleAddr[AW-1:0]] <= {{(WORD_W-SAMPLE_W){1'b0}}, delayedSample};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seenCnt   <= '0;
      tsCount   <= '0;
      headTs    <= '0;
      fillPtr   <= '0;
      commitPtr <= '0;
      rdPtr     <= '0;
      headPtr   <= '0;
    end else begin
      if (sampleValid) begin
        tsCount <= tsCount + TS_W'(1);
        if (seenCnt != SW'(PRE)) seenCnt <= seenCnt + SW'(1);
      end
      if (st.wrHeader) commitPtr <= fillPtr;
      if (st.startHead) begin
        headPtr <= fillPtr;
        headTs  <= tsCount - TS_W'(PRE);
        fillPtr <= fillPtr + (AW+1)'(2);
      end else if (st.wrSample) begin
        fillPtr <= fillPtr + (AW+1)'(1);
      end
      if (outValid && outReady) rdPtr <= rdPtr + (AW+1)'(1);
    end
  end
endmodule

// File: rtl/wave_chunker.sv
module wave_chunker
  import chunk_pkg::*;
#(
  parameter int PRE    = 2,
  parameter int POST   = 2,
  parameter int MAXLEN = 64,
  parameter int DEPTH  = 256,
  parameter int OVF_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic [SAMPLE_W-1:0] threshold,
  input  logic [CHAN_W-1:0]   channelId,
  input  logic                outReady,
  output logic                outValid,
  output logic [WORD_W-1:0]   outData,
  output logic [OVF_W-1:0]    overflowCount
);
  chunkStrobe_t st;
  logic over, delayedValid, spaceOk;

  chunk_ctrl #(.PRE(PRE), .POST(POST), .MAXLEN(MAXLEN), .OVF_W(OVF_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .over(over),
    .delayedValid(delayedValid), .spaceOk(spaceOk), .st(st),
    .overflowCount(overflowCount)
  );

  chunk_datapath #(.PRE(PRE), .DEPTH(DEPTH), .MAXLEN(MAXLEN)) u_dp (
    .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .sampleData(sampleData),
    .threshold(threshold), .channelId(channelId), .st(st), .over(over),
    .delayedValid(delayedValid), .spaceOk(spaceOk), .outReady(outReady),
    .outValid(outValid), .outData(outData)
  );
endmodule

// File: rtl/wave_chunker_chk.sv
module wave_chunker_chk #(
  parameter int OVF_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sampleValid,
  input logic             outReady,
  input logic             outValid,
  input logic [31:0]      outData,
  input logic [OVF_W-1:0] overflowCount
);
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (!outValid && overflowCount == '0));

  assert_ovf_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overflowCount != $past(overflowCount)) |->
      (overflowCount == $past(overflowCount) + OVF_W'(1)));

  assert_hold_output_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData)));

  assert_idle_no_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !sampleValid |=> $stable(overflowCount));
endmodule

bind wave_chunker wave_chunker_chk #(.OVF_W(OVF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sampleValid(sampleValid), .outReady(outReady),
  .outValid(outValid), .outData(outData), .overflowCount(overflowCount)
);

// File: tb/sim_wave_chunker.sv
module sim_wave_chunker;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] CHAN = 5'd19;

  logic clk = 0, rst_n = 0, sampleValid = 0, outReady = 0, outValid;
  logic [9:0] sampleData = 0, threshold = 10'd100;
  logic [4:0] channelId = CHAN;
  logic [31:0] outData;
  logic [15:0] overflowCount;

  int nChecks = 0, nFails = 0, idx = 0, cycles = 0;
  logic [9:0] sent [0:2047];
  logic [31:0] got [$];
  logic [31:0] expq [$];

  wave_chunker u0 (.clk(clk), .rst_n(rst_n), .sampleValid(sampleValid),
    .sampleData(sampleData), .threshold(threshold), .channelId(channelId),
    .outReady(outReady), .outValid(outValid), .outData(outData),
    .overflowCount(overflowCount));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rst_n && outValid && outReady) got.push_back(outData);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cycles);
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [9:0] v);
    sampleValid = 1; sampleData = v; sent[idx] = v; idx++;
    @(posedge clk); #1;
    sampleValid = 0;
  endtask

  task automatic quiet(input int n);
    for (int k = 0; k < n; k++) push(10'(idx % 90));
  endtask

  task automatic hit();
    push(10'(200 + idx % 800));
  endtask

  task automatic idleCycles(input int n);
    for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
  endtask

  task automatic flush();
    quiet(6);
    idleCycles(80);
  endtask

  task automatic expectChunk(input int s, input int len);
    expq.push_back({CHAN, 20'(s), 7'(len)});
    for (int k = 0; k < len; k++) expq.push_back({22'b0, sent[s+k]});
  endtask

  task automatic compareWords(input string tag);
    check(got.size() == expq.size(), {tag, " word count"}, got.size(), expq.size());
    for (int k = 0; k < expq.size() && k < got.size(); k++)
      check(got[k] == expq[k], tag, got[k], expq[k]);
    got.delete(); expq.delete();
  endtask

  task automatic testReset();
    check(outValid == 0, "R1 outValid after reset", outValid, 0);
    check(overflowCount == 0, "R1 overflowCount after reset", overflowCount, 0);
  endtask

  task automatic testSingle();
    int h;
    outReady = 1;
    quiet(10); h = idx; hit(); flush();
    expectChunk(h - 2, 5);
    compareWords("R2 R3 single hit window");
  endtask

  task automatic testEqual();
    quiet(4); push(10'd100); flush();
    compareWords("R4 sample equal to threshold");
  endtask

  task automatic testMerge();
    int h;
    quiet(4); h = idx; hit(); quiet(4); hit(); flush();
    expectChunk(h - 2, 10);
    compareWords("R5 gap five merges");
    h = idx; hit(); quiet(5); hit(); flush();
    expectChunk(h - 2, 5);
    expectChunk(h + 4, 5);
    compareWords("R5 gap six splits");
  endtask

  task automatic testGaps();
    int h;
    for (int k = 0; k < 3; k++) begin quiet(1); idleCycles(2); end
    h = idx; hit(); idleCycles(3);
    for (int k = 0; k < 6; k++) begin quiet(1); idleCycles(1); end
    idleCycles(40);
    expectChunk(h - 2, 5);
    compareWords("R10 idle cycles ignored");
  endtask

  task automatic testCap();
    int h;
    quiet(4); h = idx;
    for (int k = 0; k < 70; k++) hit();
    flush();
    expectChunk(h - 2, 64);
    expectChunk(h + 62, 10);
    compareWords("R6 split at 64");
  endtask

  task automatic testVisibility();
    int h;
    logic [31:0] held;
    outReady = 0;
    quiet(4); h = idx; hit(); quiet(2);
    #2; check(outValid == 0, "R8 hidden while open", outValid, 0);
    quiet(4); #2;
    check(outValid == 1, "R8 visible after close", outValid, 1);
    held = outData;
    check(held == {CHAN, 20'(h - 2), 7'd5}, "R8 R3 header first", held, {CHAN, 20'(h - 2), 7'd5});
    idleCycles(5); #2;
    check(outValid == 1 && outData == held, "R9 held under backpressure", outData, held);
    outReady = 1; idleCycles(20);
    expectChunk(h - 2, 5);
    compareWords("R9 drain after hold");
  endtask

  task automatic testDrop();
    int s [3];
    int h;
    outReady = 0;
    for (int c = 0; c < 3; c++) begin
      quiet(4); s[c] = idx - 0;
      for (int k = 0; k < 60; k++) hit();
      quiet(6);
    end
    quiet(4); hit(); quiet(6); #2;
    check(overflowCount == 1, "R7 overflow count after drop", overflowCount, 1);
    outReady = 1; idleCycles(220);
    for (int c = 0; c < 3; c++) expectChunk(s[c] - 2, 64);
    compareWords("R7 earlier windows intact, dropped one absent");
    h = idx + 4; quiet(4); hit(); flush();
    expectChunk(h - 2, 5);
    compareWords("R7 accepted after room returns");
    check(overflowCount == 1, "R7 count unchanged after accept", overflowCount, 1);
  endtask

  initial begin
    idleCycles(3);
    #2; testReset();
    rst_n = 1;
    @(posedge clk); #1;
    testSingle();
    testEqual();
    testMerge();
    testGaps();
    testCap();
    testVisibility();
    testDrop();
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule